// File: doc/BRIEF.md
# CPU Activity Watchdog Counter

This block supervises the processor by counting clock cycles. Software must
clear the counter regularly by writing the control register with the clear
bit at 0; if it fails to do so before the counter reaches its terminal count,
the block raises a one-cycle reset request and the count starts over. The
standard software clear is the byte 0x35, whose clear bit is 0.

The counter is also cleared whenever the system enters a state in which no
software runs. A bus hold starting, sleep entry, and timer-mode entry each
arrive as single-cycle strobes and each clears the count. A stopped main
oscillator is a level that holds the count at zero for as long as it lasts.
None of these states can therefore produce a reset request. The clear bit
always reads back as 1, and the other control bits keep what was last written.

Top module: `cpu_activity_wdt`

## Requirements
- R1: After reset, `rst_req` is 0, `reg_rdata` is 0x02, and the counter starts from zero: the first request appears after 2^CNT_W rising edges without a clear.
- R2: Without any clear the counter advances by one per cycle. An edge that sees the count at 2^CNT_W-1 sets it to 0 and raises `rst_req` for exactly one cycle, so requests repeat every 2^CNT_W cycles.
- R3: A write with bit 1 of `reg_wdata` at 0 (for example 0x35) sets the count to 0 at that edge; the next request follows 2^CNT_W cycles later.
- R4: A write with bit 1 at 1 leaves the count running. Bit 1 of `reg_rdata` always reads 1, and every other bit of `reg_rdata` holds the value last written to it (0x35 reads back as 0x37, 0xFF as 0xFF).
- R5: While `osc_stopped` is 1 the count stays at 0 and no request is raised, however long it lasts; the count resumes from 0 once it falls.
- R6: A one-cycle pulse on `sleep_enter` sets the count to 0.
- R7: A one-cycle pulse on `timer_enter` sets the count to 0.
- R8: A one-cycle pulse on `hold_start` sets the count to 0.
- R9: A clear from any source at the same edge as the terminal count wins: no request is raised and the count becomes 0.
- R10: Driving `rst_n` low clears the count, the request and the control register at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| osc_stopped | input | 1 | Main oscillator stopped (level) |
| sleep_enter | input | 1 | Sleep entry strobe |
| timer_enter | input | 1 | Timer-mode entry strobe |
| hold_start | input | 1 | Bus hold start strobe |
| rst_req | output | 1 | Reset request, one-cycle pulse |

## Verification
A wrong count shows at the ports only through the timing of `rst_req`, so every
clear is followed by a measurement of the gap to the next request; an error
of one cycle in the count or in a clear moves that pulse by one cycle and is
seen within one terminal period. A clear source that is ignored, or a terminal
check that beats a clear, shows as an extra pulse inside that same period. A
cycle-by-cycle scoreboard compares `rst_req` against an independent count model
on every cycle, and the control readback is checked right after each write.

// File: rtl/cpu_wdt_pkg.sv
package cpu_wdt_pkg;

   // Every event that forces the supervisor count back to zero.
   typedef struct packed {
      logic sw_clr;
      logic osc_off;
      logic sleep_go;
      logic tmode_go;
      logic hold_go;
   } wdt_clr_src_t;

   localparam int unsigned WDT_NUM_SRC = $bits(wdt_clr_src_t);

   // What the counter does at the coming edge.
   typedef enum logic [1:0] {
      CNT_RUN    = 2'd0,
      CNT_CLEAR  = 2'd1,
      CNT_EXPIRE = 2'd2
   } wdt_cnt_act_e;

endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg #(
   parameter int unsigned     CTL_W   = 8,
   parameter int unsigned     CLR_POS = 1,
   parameter logic [CTL_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] rdata,
   output logic             sw_clear
);

   initial begin : elab_chk
      if (CLR_POS >= CTL_W) $error("wdt_ctl_reg: CLR_POS outside register");
   end

   // Writing 0 into the clear position is the software kick.
   assign sw_clear = we & ~wdata[CLR_POS];

   for (genvar b = 0; b < CTL_W; b++) begin : g_bit
      if (b == CLR_POS) begin : g_clr
         assign rdata[b] = 1'b1;
      end else begin : g_store
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  bit_q <= RST_VAL[b];
            else if (we) bit_q <= wdata[b];
         end
         assign rdata[b] = bit_q;
      end
   end

endmodule

// File: rtl/wdt_clr_merge.sv
module wdt_clr_merge
   import cpu_wdt_pkg::*;
#(
   parameter logic [WDT_NUM_SRC-1:0] SRC_EN = '1
) (
   input  wdt_clr_src_t src,
   output logic         clr
);

   logic [WDT_NUM_SRC-1:0] src_vec;
   logic [WDT_NUM_SRC-1:0] gated;

   assign src_vec = src;

   for (genvar s = 0; s < WDT_NUM_SRC; s++) begin : g_src
      if (SRC_EN[s]) begin : g_on
         assign gated[s] = src_vec[s];
      end else begin : g_off
         assign gated[s] = 1'b0;
      end
   end

   assign clr = |gated;

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
   import cpu_wdt_pkg::*;
#(
   parameter int unsigned      CNT_W    = 20,
   parameter logic [CNT_W-1:0] TERM_CNT = {CNT_W{1'b1}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             req
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   initial begin : elab_chk
      if (CNT_W < 2) $error("wdt_tick_counter: CNT_W must be at least 2");
      if (TERM_CNT == '0) $error("wdt_tick_counter: TERM_CNT must be nonzero");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             req_q;
   logic             at_term;
   wdt_cnt_act_e     act;

   // Full-range terminal uses an AND tree; a shorter one needs a comparator.
   if (TERM_CNT == ALL_ONES) begin : g_term_full
      assign at_term = &cnt_q;
   end else begin : g_term_cmp
      assign at_term = (cnt_q == TERM_CNT);
   end

   // Clear sources outrank the terminal count.
   always_comb begin
      if (clr)          act = CNT_CLEAR;
      else if (at_term) act = CNT_EXPIRE;
      else              act = CNT_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         unique case (act)
            CNT_CLEAR: begin
               cnt_q <= '0;
               req_q <= 1'b0;
            end
            CNT_EXPIRE: begin
               cnt_q <= '0;
               req_q <= 1'b1;
            end
            default: begin
               cnt_q <= cnt_q + 1'b1;
               req_q <= 1'b0;
            end
         endcase
      end
   end

   assign cnt = cnt_q;
   assign req = req_q;

endmodule

// File: rtl/cpu_activity_wdt.sv
module cpu_activity_wdt
   import cpu_wdt_pkg::*;
#(
   parameter int unsigned      CNT_W    = 20,
   parameter logic [CNT_W-1:0] TERM_CNT = {CNT_W{1'b1}},
   parameter int unsigned      CTL_W    = 8,
   parameter int unsigned      CLR_POS  = 1,
   parameter logic [CTL_W-1:0] CTL_RST  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [CTL_W-1:0] reg_wdata,
   output logic [CTL_W-1:0] reg_rdata,
   input  logic             osc_stopped,
   input  logic             sleep_enter,
   input  logic             timer_enter,
   input  logic             hold_start,
   output logic             rst_req
);

   logic             sw_kick;
   logic             any_clr;
   logic [CNT_W-1:0] cnt_value;
   wdt_clr_src_t     clr_src;

   wdt_ctl_reg #(
      .CTL_W  (CTL_W),
      .CLR_POS(CLR_POS),
      .RST_VAL(CTL_RST)
   ) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .sw_clear(sw_kick)
   );

   always_comb begin
      clr_src.sw_clr   = sw_kick;
      clr_src.osc_off  = osc_stopped;
      clr_src.sleep_go = sleep_enter;
      clr_src.tmode_go = timer_enter;
      clr_src.hold_go  = hold_start;
   end

   wdt_clr_merge #(
      .SRC_EN('1)
   ) u_merge (
      .src(clr_src),
      .clr(any_clr)
   );

   wdt_tick_counter #(
      .CNT_W   (CNT_W),
      .TERM_CNT(TERM_CNT)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (any_clr),
      .cnt  (cnt_value),
      .req  (rst_req)
   );

endmodule

// File: rtl/cpu_activity_wdt_chk.sv
module cpu_activity_wdt_chk #(
   parameter int unsigned      CNT_W    = 20,
   parameter logic [CNT_W-1:0] TERM_CNT = {CNT_W{1'b1}},
   parameter int unsigned      CTL_W    = 8,
   parameter int unsigned      CLR_POS  = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [CTL_W-1:0] reg_wdata,
   input logic [CTL_W-1:0] reg_rdata,
   input logic             osc_stopped,
   input logic             sleep_enter,
   input logic             timer_enter,
   input logic             hold_start,
   input logic             rst_req,
   input logic [CNT_W-1:0] cnt
);

   localparam logic [CTL_W-1:0] CL_MASK = CTL_W'(1) << CLR_POS;

   logic             sw_kick;
   logic             any_kick;
   logic [CNT_W-1:0] cnt_inc;

   assign sw_kick  = reg_we && !reg_wdata[CLR_POS];
   assign any_kick = sw_kick || osc_stopped || sleep_enter || timer_enter || hold_start;
   assign cnt_inc  = cnt + 1'b1;

   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_pulse_at_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_kick && cnt == TERM_CNT) |=> (rst_req && cnt == '0));

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_kick && cnt != TERM_CNT) |=> (cnt == $past(cnt_inc) && !rst_req));

   assert_sw_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_kick |=> (cnt == '0 && !rst_req));

   assert_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_rdata == ($past(reg_wdata) | CL_MASK)));

   assert_osc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      osc_stopped |=> (cnt == '0 && !rst_req));

   assert_sleep_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_enter |=> (cnt == '0 && !rst_req));

   assert_timer_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      timer_enter |=> (cnt == '0 && !rst_req));

   assert_hold_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_start |=> (cnt == '0 && !rst_req));

   assert_clear_beats_term_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (any_kick && cnt == TERM_CNT) |=> !rst_req);

endmodule

bind cpu_activity_wdt cpu_activity_wdt_chk #(
   .CNT_W   (CNT_W),
   .TERM_CNT(TERM_CNT),
   .CTL_W   (CTL_W),
   .CLR_POS (CLR_POS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .osc_stopped(osc_stopped),
   .sleep_enter(sleep_enter),
   .timer_enter(timer_enter),
   .hold_start (hold_start),
   .rst_req    (rst_req),
   .cnt        (cnt_value)
);

// File: tb/cpu_activity_wdt_test.sv
`timescale 1ns/1ps
module cpu_activity_wdt_test;

   localparam int CW     = 6;
   localparam int PERIOD = 1 << CW;
   localparam int TERM   = PERIOD - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       osc_stopped = 1'b0;
   logic       sleep_enter = 1'b0;
   logic       timer_enter = 1'b0;
   logic       hold_start = 1'b0;
   logic       rst_req;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cpu_activity_wdt #(.CNT_W(CW)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .osc_stopped(osc_stopped),
      .sleep_enter(sleep_enter),
      .timer_enter(timer_enter),
      .hold_start (hold_start),
      .rst_req    (rst_req)
   );

   task automatic chk_eq(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Scoreboard: the model pushes the expected request per edge,
   // the monitor pops and compares at the following falling edge.
   bit exp_q[$];
   int m_cnt = 0;

   always @(posedge clk) begin
      bit kick;
      if (!rst_n) begin
         m_cnt = 0;
         exp_q.push_back(1'b0);
      end else begin
         kick = (reg_we && !reg_wdata[1]) || osc_stopped || sleep_enter
                || timer_enter || hold_start;
         if (kick) begin
            m_cnt = 0;
            exp_q.push_back(1'b0);
         end else if (m_cnt == TERM) begin
            m_cnt = 0;
            exp_q.push_back(1'b1);
         end else begin
            m_cnt++;
            exp_q.push_back(1'b0);
         end
      end
   end

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         bit e;
         e = exp_q.pop_front();
         checks++;
         if (rst_req !== e) begin
            errors++;
            $display("FAIL R2 scoreboard actual %0d expected %0d", rst_req, e);
         end
      end
   end

   // Strobe one source for a single edge; returns on the falling edge
   // just after the edge that sampled it.
   task automatic pulse_src(int which, logic [7:0] data);
      @(negedge clk);
      case (which)
         0: begin reg_we = 1'b1; reg_wdata = data; end
         1: sleep_enter = 1'b1;
         2: timer_enter = 1'b1;
         default: hold_start = 1'b1;
      endcase
      @(negedge clk);
      reg_we = 1'b0;
      sleep_enter = 1'b0;
      timer_enter = 1'b0;
      hold_start = 1'b0;
   endtask

   // Expect the first request on exactly the n-th coming falling edge.
   task automatic expect_pulse_after(int n, string req);
      int first = 0;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         if (rst_req && first == 0) first = i;
      end
      chk_eq(req, first, n);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int seen;
      idle(3);
      chk_eq("R1 request in reset", rst_req, 0);
      chk_eq("R1 readback in reset", reg_rdata, 8'h02);
      rst_n = 1'b1;
      expect_pulse_after(PERIOD, "R1 first request");
      @(negedge clk);
      chk_eq("R2 pulse width", rst_req, 0);
      expect_pulse_after(PERIOD - 1, "R2 period");

      idle(20);
      pulse_src(0, 8'h35);
      expect_pulse_after(PERIOD, "R3 software clear");
      chk_eq("R4 readback 0x35", reg_rdata, 8'h37);

      idle(10);
      pulse_src(0, 8'hFF);
      expect_pulse_after(PERIOD - 12, "R4 write with bit 1 set");
      chk_eq("R4 readback 0xFF", reg_rdata, 8'hFF);

      idle(5);
      @(negedge clk);
      osc_stopped = 1'b1;
      seen = 0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (rst_req) seen++;
      end
      chk_eq("R5 no request while stopped", seen, 0);
      osc_stopped = 1'b0;
      expect_pulse_after(PERIOD, "R5 resume from zero");

      idle(30);
      pulse_src(1, 8'h00);
      expect_pulse_after(PERIOD, "R6 sleep entry");
      idle(17);
      pulse_src(2, 8'h00);
      expect_pulse_after(PERIOD, "R7 timer entry");
      idle(41);
      pulse_src(3, 8'h00);
      expect_pulse_after(PERIOD, "R8 hold start");

      idle(PERIOD - 2);
      pulse_src(0, 8'h35);
      chk_eq("R9 clear at terminal", rst_req, 0);
      expect_pulse_after(PERIOD, "R9 restart after clear");
      chk_eq("R9 readback", reg_rdata, 8'h37);

      idle(20);
      rst_n = 1'b0;
      #1;
      chk_eq("R10 async request", rst_req, 0);
      chk_eq("R10 async readback", reg_rdata, 8'h02);
      @(negedge clk);
      rst_n = 1'b1;
      expect_pulse_after(PERIOD, "R10 count from zero");

      idle(2);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule